// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block decides which operating mode a CAN controller core is in and applies it to the signals around the frame engine. Two register write ports feed it. A control write carries a core-enable bit and a self-clearing soft-reset bit. A mode-select write carries three option bits, and it is accepted only while the core is held in configuration. When enable goes high, the block leaves configuration for the mode that the select bits choose. With no select bit set, that mode is normal.

The current mode drives several things. It decides whether the physical transmit line follows the frame engine or stays recessive. It picks whether the internal receive line comes from the bus pin, from the engine's own transmit bit, or is held recessive. It gates the transmit-request flags from the FIFO and the priority buffer. It enables reception and self-acknowledgement, and it holds the error counters clear while in configuration. Sleep is left only on bus activity, never because a transmit is pending. Entering and leaving sleep each raise a one-cycle event pulse. The mode is reported as one-hot flags placed at fixed positions in a status word.

Top module: `can_mode_seq`

## Requirements
- R1: While in configuration mode (after reset, or while enable is low), the transmit pin is 1 (recessive) and the error-clear output is 1. Both transmit-go outputs are 0 whatever the pending flags are, the receive enable is 0 and the internal receive line is 1.
- R2: The control write field is bit 1 = enable and bit 0 = soft reset. A write with bit 0 set returns the block to configuration, with enable and the select bits cleared, on the next edge. The reset does not persist, so an enable write in the following cycle takes effect normally.
- R3: The mode-select write field is bit 0 = sleep, bit 1 = loop-back and bit 2 = snoop. It is stored only if the block is in configuration when the write occurs. Otherwise it is ignored, and re-entering a mode later shows that the old selection is still in force.
- R4: A control write with enable set, made while in configuration, changes the mode at that same clock edge. The stored select bits choose the mode with loop-back first, then snoop, then sleep. With no bit set the mode is normal.
- R5: The status word has configuration at bit 0, loop-back at bit 1, sleep at bit 2, normal at bit 3 and snoop at bit 12. Exactly one of these bits is set and every other bit is 0.
- R6: In normal mode the transmit pin follows the engine's transmit bit and the internal receive line follows the bus pin. Each transmit-go output equals its pending flag, and receive is enabled.
- R7: In sleep mode the transmit pin is recessive and both transmit-go outputs are 0. Pending transmit flags never end sleep. Receive stays enabled with the internal line taken from the bus pin, so the waking frame is captured.
- R8: Bus activity seen at an edge while in sleep moves the block to normal at that edge. A wake pulse is high for exactly that one cycle, and the sleep status flag clears.
- R9: A sleep pulse is high for exactly the one cycle after the edge at which the block enters sleep.
- R10: In loop-back mode the transmit pin is recessive and the internal receive line equals the engine's transmit bit, whatever the bus pin does. Self-acknowledge is 1 and transmit requests are passed through.
- R11: In snoop mode the transmit pin is recessive, both transmit-go outputs are 0, the internal receive line follows the bus pin and receive is enabled.
- R12: A control write with enable cleared returns the block from any mode to configuration at the next edge, and no wake pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data: bit 1 enable, bit 0 soft reset |
| sel_wr | input | 1 | Mode-select write strobe |
| sel_wdata | input | 3 | Select data: bit 0 sleep, bit 1 loop-back, bit 2 snoop |
| bus_activity | input | 1 | Another node is active on the bus |
| tx_pend_fifo | input | 1 | Transmit FIFO has a frame pending |
| tx_pend_prio | input | 1 | Priority buffer has a frame pending |
| core_tx | input | 1 | Transmit bit from the frame engine |
| can_rx_raw | input | 1 | Receive bit from the bus pin |
| can_tx | output | 1 | Bus transmit drive (1 = recessive) |
| rx_line | output | 1 | Receive bit delivered to the frame engine |
| tx_fifo_go | output | 1 | FIFO transmit request allowed to the engine |
| tx_prio_go | output | 1 | Priority-buffer transmit request allowed |
| rx_en | output | 1 | Frame reception enabled |
| self_ack | output | 1 | Engine acknowledges its own frames |
| err_clr | output | 1 | Holds the error counters at zero |
| sleep_evt | output | 1 | One-cycle pulse on entering sleep |
| wake_evt | output | 1 | One-cycle pulse on waking from sleep |
| mode_status | output | 13 | One-hot mode flags at bits 0, 1, 2, 3 and 12 |

## Verification
If the mode register held the wrong state, the status word would show it in the very next cycle. The transmit pin and receive routing would also diverge as soon as the engine bit and the bus bit differ from each other. A select register that was corrupted or wrongly written becomes visible only when enable next rises, because the chosen mode then differs. A wrong wake or sleep decision shows as a missing or extra event pulse in the cycle after the deciding edge. The bench compares every output against a behavioural model on every cycle, so each of these shows up at its first appearance.

// File: rtl/can_mode_seq.sv
module can_mode_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [1:0]  ctl_wdata,
  input  logic        sel_wr,
  input  logic [2:0]  sel_wdata,
  input  logic        bus_activity,
  input  logic        tx_pend_fifo,
  input  logic        tx_pend_prio,
  input  logic        core_tx,
  input  logic        can_rx_raw,
  output logic        can_tx,
  output logic        rx_line,
  output logic        tx_fifo_go,
  output logic        tx_prio_go,
  output logic        rx_en,
  output logic        self_ack,
  output logic        err_clr,
  output logic        sleep_evt,
  output logic        wake_evt,
  output logic [12:0] mode_status
);

  localparam int ST_CFG   = 0;
  localparam int ST_LOOP  = 1;
  localparam int ST_SLEEP = 2;
  localparam int ST_NORM  = 3;
  localparam int ST_SNOOP = 12;

  typedef enum logic [2:0] {M_CFG, M_NORM, M_SLEEP, M_LOOP, M_SNOOP} mode_t;

  mode_t      mode_q, mode_d;
  logic       en_q, en_d;
  logic [2:0] sel_q;
  logic       srst;

  assign srst = ctl_wr & ctl_wdata[0];
  assign en_d = ctl_wr ? ctl_wdata[1] : en_q;

  always_comb begin
    mode_d = mode_q;
    if (!en_d)
      mode_d = M_CFG;
    else if (mode_q == M_CFG) begin
      if (sel_q[1])      mode_d = M_LOOP;
      else if (sel_q[2]) mode_d = M_SNOOP;
      else if (sel_q[0]) mode_d = M_SLEEP;
      else               mode_d = M_NORM;
    end else if (mode_q == M_SLEEP && bus_activity)
      mode_d = M_NORM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_CFG;
      en_q      <= 1'b0;
      sel_q     <= '0;
      sleep_evt <= 1'b0;
      wake_evt  <= 1'b0;
    end else if (srst) begin
      mode_q    <= M_CFG;
      en_q      <= 1'b0;
      sel_q     <= '0;
      sleep_evt <= 1'b0;
      wake_evt  <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      en_q      <= en_d;
      if (sel_wr && mode_q == M_CFG)
        sel_q <= sel_wdata;
      sleep_evt <= (mode_d == M_SLEEP) && (mode_q != M_SLEEP);
      wake_evt  <= (mode_q == M_SLEEP) && (mode_d == M_NORM);
    end
  end

  logic in_cfg, in_norm, in_sleep, in_loop, in_snoop;
  assign in_cfg   = mode_q == M_CFG;
  assign in_norm  = mode_q == M_NORM;
  assign in_sleep = mode_q == M_SLEEP;
  assign in_loop  = mode_q == M_LOOP;
  assign in_snoop = mode_q == M_SNOOP;

  assign can_tx     = in_norm ? core_tx : 1'b1;
  assign rx_line    = in_loop ? core_tx : (in_cfg ? 1'b1 : can_rx_raw);
  assign tx_fifo_go = (in_norm | in_loop) & tx_pend_fifo;
  assign tx_prio_go = (in_norm | in_loop) & tx_pend_prio;
  assign rx_en      = ~in_cfg;
  assign self_ack   = in_loop;
  assign err_clr    = in_cfg;

  always_comb begin
    mode_status           = '0;
    mode_status[ST_CFG]   = in_cfg;
    mode_status[ST_LOOP]  = in_loop;
    mode_status[ST_SLEEP] = in_sleep;
    mode_status[ST_NORM]  = in_norm;
    mode_status[ST_SNOOP] = in_snoop;
  end

endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic        bus_activity,
  input logic        core_tx,
  input logic        can_rx_raw,
  input logic        can_tx,
  input logic        rx_line,
  input logic        tx_fifo_go,
  input logic        tx_prio_go,
  input logic        rx_en,
  input logic        self_ack,
  input logic        err_clr,
  input logic        sleep_evt,
  input logic        wake_evt,
  input logic [12:0] mode_status
);

  // R1
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_status[0] |-> can_tx && err_clr && !tx_fifo_go && !tx_prio_go && !rx_en);

  // R5
  one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_status) == 1);

  // R7
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_status[2] && !bus_activity && !ctl_wr |=> mode_status[2]);

  // R8
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> mode_status[3] && $past(mode_status[2]));

  // R9
  sleep_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_evt |-> mode_status[2] && !$past(mode_status[2]));

  // R10
  loop_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_status[1] |-> (rx_line == core_tx) && can_tx && self_ack);

  // R11
  snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_status[12] |-> can_tx && !tx_fifo_go && !tx_prio_go && (rx_line == can_rx_raw) && rx_en);

endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .bus_activity(bus_activity),
  .core_tx(core_tx), .can_rx_raw(can_rx_raw), .can_tx(can_tx), .rx_line(rx_line),
  .tx_fifo_go(tx_fifo_go), .tx_prio_go(tx_prio_go), .rx_en(rx_en),
  .self_ack(self_ack), .err_clr(err_clr), .sleep_evt(sleep_evt),
  .wake_evt(wake_evt), .mode_status(mode_status)
);

// File: tb/test_can_mode_seq.sv
`timescale 1ns/1ps
module test_can_mode_seq;
  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, sel_wr = 0, bus_activity = 0, tx_pend_fifo = 0, tx_pend_prio = 0;
  logic core_tx = 1, can_rx_raw = 1;
  logic [1:0] ctl_wdata = 0;
  logic [2:0] sel_wdata = 0;
  logic can_tx, rx_line, tx_fifo_go, tx_prio_go, rx_en, self_ack, err_clr, sleep_evt, wake_evt;
  logic [12:0] mode_status;

  always #2.5 clk = ~clk;

  can_mode_seq i_can_mode_seq (.*);

  int total = 0, fails = 0, cycles = 0;
  bit done = 0;
  // model: 0 cfg, 1 normal, 2 sleep, 3 loop, 4 snoop
  int m_mode = 0;
  bit m_en = 0, m_sp = 0, m_wp = 0;
  bit [2:0] m_sel = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] st_of(input int m);
    logic [12:0] s = '0;
    case (m)
      0: s[0] = 1;
      1: s[3] = 1;
      2: s[2] = 1;
      3: s[1] = 1;
      default: s[12] = 1;
    endcase
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || (ctl_wr && ctl_wdata[0])) begin
      m_mode = 0; m_en = 0; m_sel = 0; m_sp = 0; m_wp = 0;
    end else begin
      bit ne;
      int nm;
      ne = ctl_wr ? ctl_wdata[1] : m_en;
      nm = m_mode;
      if (!ne) nm = 0;
      else if (m_mode == 0) nm = m_sel[1] ? 3 : m_sel[2] ? 4 : m_sel[0] ? 2 : 1;
      else if (m_mode == 2 && bus_activity) nm = 1;
      m_sp = (nm == 2) && (m_mode != 2);
      m_wp = (m_mode == 2) && (nm == 1);
      if (sel_wr && m_mode == 0) m_sel = sel_wdata;
      m_en = ne;
      m_mode = nm;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      string tag;
      bit go;
      case (m_mode)
        0: tag = "R1";
        1: tag = "R6";
        2: tag = "R7";
        3: tag = "R10";
        default: tag = "R11";
      endcase
      go = (m_mode == 1 || m_mode == 3);
      chk("R5 status", 32'(mode_status), 32'(st_of(m_mode)));
      chk({tag, " can_tx"}, 32'(can_tx), 32'(m_mode == 1 ? core_tx : 1'b1));
      chk({tag, " rx_line"}, 32'(rx_line),
          32'(m_mode == 3 ? core_tx : m_mode == 0 ? 1'b1 : can_rx_raw));
      chk({tag, " tx go"}, {30'b0, tx_fifo_go, tx_prio_go},
          {30'b0, go & tx_pend_fifo, go & tx_pend_prio});
      chk({tag, " rx_en/ack/clr"}, {29'b0, rx_en, self_ack, err_clr},
          {29'b0, m_mode != 0, m_mode == 3, m_mode == 0});
      chk("R9 sleep_evt", 32'(sleep_evt), 32'(m_sp));
      chk("R8 wake_evt", 32'(wake_evt), 32'(m_wp));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic wr_ctl(input logic [1:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic wr_sel(input logic [2:0] v);
    @(negedge clk); sel_wr = 1; sel_wdata = v;
    @(negedge clk); sel_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      core_tx = ~core_tx;
      can_rx_raw = (i % 3) == 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2 chk("R1 reset status", 32'(mode_status), 32'h001);
    tx_pend_fifo = 1; tx_pend_prio = 1;
    idle(4);
    // R4: no select bit gives normal
    wr_ctl(2'b10);
    #2 chk("R4 normal selected", 32'(mode_status), 32'h008);
    idle(6);
    // R3: select ignored outside configuration
    wr_sel(3'b010);
    #2 chk("R3 select ignored", 32'(mode_status), 32'h008);
    // R12: disable returns to configuration
    wr_ctl(2'b00);
    #2 chk("R12 back to config", 32'(mode_status), 32'h001);
    wr_ctl(2'b10);
    #2 chk("R3 old select kept", 32'(mode_status), 32'h008);
    wr_ctl(2'b00);
    // sleep: pendings must not wake (R7), activity wakes (R8)
    wr_sel(3'b001);
    wr_ctl(2'b10);
    #2 chk("R9 entered sleep", 32'(mode_status), 32'h004);
    idle(8);
    #2 chk("R7 pending does not wake", 32'(mode_status), 32'h004);
    @(negedge clk); bus_activity = 1;
    @(negedge clk); bus_activity = 0;
    #2 chk("R8 woke to normal", 32'(mode_status), 32'h008);
    idle(3);
    wr_ctl(2'b00);
    // R4 priority: loop over snoop
    wr_sel(3'b111);
    wr_ctl(2'b10);
    #2 chk("R10 loop chosen", 32'(mode_status), 32'h002);
    idle(8);
    wr_ctl(2'b00);
    wr_sel(3'b101);
    wr_ctl(2'b10);
    #2 chk("R11 snoop chosen", 32'(mode_status), 32'h1000);
    idle(8);
    // R2: soft reset, then immediate enable gives normal (select cleared)
    wr_ctl(2'b11);
    #2 chk("R2 soft reset", 32'(mode_status), 32'h001);
    wr_ctl(2'b10);
    #2 chk("R2 enable after reset", 32'(mode_status), 32'h008);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ctl_wr = ($urandom % 12) == 0;
      ctl_wdata = {1'($urandom % 3 != 0), 1'($urandom % 6 == 0)};
      sel_wr = ($urandom % 6) == 0;
      sel_wdata = 3'($urandom);
      bus_activity = ($urandom % 10) == 0;
      tx_pend_fifo = 1'($urandom);
      tx_pend_prio = 1'($urandom);
      core_tx = 1'($urandom);
      can_rx_raw = 1'($urandom);
    end
    @(negedge clk);
    ctl_wr = 0; sel_wr = 0;
    @(negedge clk); #2;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule